// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the arithmetic and logic stage of an 8-bit accumulator processor. For one operation per clock it takes the accumulator, a second operand, the current flag byte, two 16-bit register pairs and a core-mode select. It returns a new 8-bit result, a new flag byte and a 16-bit pair sum. Register-file access, instruction decode and memory traffic belong to the surrounding core. The block only computes values and registers them once.

The flag byte holds sign, zero, half-carry, parity, carry and a combined subtract/overflow marker. Each class of operation has its own rule for which of these it recomputes and which it carries over. The core mode changes only the half-carry produced by AND. Every output is registered, so a result appears one clock after its inputs are presented.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `res_q`, `flags_q` and `wide_q` are all zero.
- R2: ADD (`op`=0) forms `acc+opnd`. ADC (`op`=1) forms `acc+opnd+flags_in[0]`. For both, the carry is bit 8 of the sum and the half-carry is bit 4 of (acc XOR opnd XOR sum). Bit 1 is cleared.
- R3: SUB (`op`=2) forms `acc-opnd`. SBB (`op`=3) forms `acc-opnd-flags_in[0]`. For both, the carry is bit 8 of the 9-bit difference (the borrow), the half-carry is the inverse of bit 4 of (acc XOR opnd XOR difference), and bit 1 is set.
- R4: CMP (`op`=4) produces the same flags as SUB, and `res_q` equals the accumulator unchanged.
- R5: AND (`op`=5) clears carry. In enhanced mode (`mode_enh`=1) the half-carry is always set. In legacy mode it equals bit 3 of (acc OR opnd).
- R6: XOR (`op`=6) and OR (`op`=7) clear both carry and half-carry.
- R7: The flag layout is sign=bit 7, zero=bit 6, half-carry=bit 4, parity=bit 2, subtract/overflow=bit 1, carry=bit 0. Bits 5 and 3 are zero. For operations 0 to 9, sign, zero and parity come from the 8-bit outcome: the result, or for CMP the difference. Parity is 1 when the count of ones is even.
- R8: INC (`op`=8) returns `opnd+1` and keeps the incoming carry. Its half-carry is set when the low nibble of `opnd` was 0xF. Bit 1 is cleared.
- R9: DEC (`op`=9) returns `opnd-1` and keeps the incoming carry. Its half-carry is set when the low nibble of `opnd` was nonzero. Bit 1 is set.
- R10: WADD (`op`=10) returns `pair_a+pair_b` (mod 2^16) on `wide_q`. Flag bit 0 becomes bit 16 of that sum, and every other flag bit is copied from `flags_in`. For every operation other than WADD, `wide_q` equals `pair_a`.
- R11: Op codes 11 to 15 pass `acc` to `res_q` and `flags_in` to `flags_q` unchanged.
- R12: Outputs change only on a rising clock edge, one cycle after the inputs they reflect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation select |
| mode_enh | input | 1 | 1 = enhanced core, 0 = legacy core |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Second operand, or the register for INC/DEC |
| flags_in | input | 8 | Current flag byte |
| pair_a | input | 16 | 16-bit addend (destination pair) |
| pair_b | input | 16 | 16-bit addend (source pair) |
| res_q | output | 8 | Registered 8-bit result |
| flags_q | output | 8 | Registered new flag byte |
| wide_q | output | 16 | Registered 16-bit pair result |

## Verification
The assertions assume that every input is stable and known at each rising edge outside reset, and that `op` is held for a whole cycle. They also assume the first cycle after reset release carries no meaningful history. For that reason they are gated by a flag that marks one completed post-reset cycle. The stimulus changes inputs only on falling edges, drives all of them to defined values during reset, and covers every op code as well as the unused ones.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_XOR  = 4'd6,
        OP_OR   = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_WADD = 4'd10
    } alu_op_e;

    localparam int FLAG_W = 8;
    localparam int FB_S   = 7;
    localparam int FB_Z   = 6;
    localparam int FB_H   = 4;
    localparam int FB_P   = 2;
    localparam int FB_V   = 1;
    localparam int FB_C   = 0;

    // Bit whose carry-in defines the half-carry
    localparam int HALF_BIT = 4;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              half
);
    import acc_alu_pkg::*;

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]  full;
    logic [DATA_W-1:0] mix;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        end
        sum   = full[DATA_W-1:0];
        carry = full[DATA_W];
        mix   = a ^ b ^ full[DATA_W-1:0];
        half  = sub ? ~mix[HALF_BIT] : mix[HALF_BIT];
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        sel,   // 0 AND, 1 XOR, 2 OR
    input  logic              enh,
    output logic [DATA_W-1:0] res,
    output logic              half
);
    import acc_alu_pkg::*;

    logic [DATA_W-1:0] either;

    always_comb begin
        either = a | b;
        half   = 1'b0;
        unique case (sel)
            2'd0: begin
                res  = a & b;
                half = enh ? 1'b1 : either[HALF_BIT-1];
            end
            2'd1:    res = a ^ b;
            default: res = either;
        endcase
    end

endmodule

// File: rtl/acc_alu_step.sv
module acc_alu_step #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] v,
    input  logic              dec,
    output logic [DATA_W-1:0] res,
    output logic              half
);
    import acc_alu_pkg::*;

    logic [HALF_BIT-1:0] low;

    always_comb begin
        low = v[HALF_BIT-1:0];
        if (dec) begin
            res  = v - 1'b1;
            half = (low != '0);
        end else begin
            res  = v + 1'b1;
            half = (low == '1);
        end
    end

endmodule

// File: rtl/acc_alu_wide.sv
module acc_alu_wide #(
    parameter int PAIR_W = 16
) (
    input  logic [PAIR_W-1:0] a,
    input  logic [PAIR_W-1:0] b,
    output logic [PAIR_W-1:0] sum,
    output logic              carry
);
    logic [PAIR_W:0] full;

    always_comb begin
        full  = {1'b0, a} + {1'b0, b};
        sum   = full[PAIR_W-1:0];
        carry = full[PAIR_W];
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DATA_W = 8,
    parameter int PAIR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op,
    input  logic                mode_enh,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   opnd,
    input  logic [7:0]          flags_in,
    input  logic [PAIR_W-1:0]   pair_a,
    input  logic [PAIR_W-1:0]   pair_b,
    output logic [DATA_W-1:0]   res_q,
    output logic [7:0]          flags_q,
    output logic [PAIR_W-1:0]   wide_q
);
    import acc_alu_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flags;
        logic [PAIR_W-1:0] wide;
    } alu_state_t;

    alu_state_t st_d, st_q;

    // ---------------- datapath units ----------------
    logic              ar_sub, ar_cin, ar_carry, ar_half;
    logic [DATA_W-1:0] ar_sum;
    logic [1:0]        lg_sel;
    logic [DATA_W-1:0] lg_res;
    logic              lg_half;
    logic [DATA_W-1:0] sp_res;
    logic              sp_half;
    logic [PAIR_W-1:0] wd_sum;
    logic              wd_carry;

    always_comb begin
        ar_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        ar_cin = ((op == OP_ADC) || (op == OP_SBB)) ? flags_in[FB_C] : 1'b0;
        unique case (op)
            OP_XOR:  lg_sel = 2'd1;
            OP_OR:   lg_sel = 2'd2;
            default: lg_sel = 2'd0;
        endcase
    end

    acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a(acc), .b(opnd), .cin(ar_cin), .sub(ar_sub),
        .sum(ar_sum), .carry(ar_carry), .half(ar_half)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a(acc), .b(opnd), .sel(lg_sel), .enh(mode_enh),
        .res(lg_res), .half(lg_half)
    );

    acc_alu_step #(.DATA_W(DATA_W)) u_step (
        .v(opnd), .dec(op == OP_DEC), .res(sp_res), .half(sp_half)
    );

    acc_alu_wide #(.PAIR_W(PAIR_W)) u_wide (
        .a(pair_a), .b(pair_b), .sum(wd_sum), .carry(wd_carry)
    );

    // Assemble a full flag byte from an 8-bit outcome
    function automatic logic [FLAG_W-1:0] pack_flags(
        input logic [DATA_W-1:0] r,
        input logic              h,
        input logic              v,
        input logic              c
    );
        logic [FLAG_W-1:0] f;
        f       = '0;
        f[FB_S] = r[DATA_W-1];
        f[FB_Z] = (r == '0);
        f[FB_H] = h;
        f[FB_P] = ~^r;
        f[FB_V] = v;
        f[FB_C] = c;
        return f;
    endfunction

    // ---------------- next-state ----------------
    always_comb begin
        st_d.res   = acc;
        st_d.flags = flags_in;
        st_d.wide  = pair_a;
        unique case (op)
            OP_ADD, OP_ADC: begin
                st_d.res   = ar_sum;
                st_d.flags = pack_flags(ar_sum, ar_half, 1'b0, ar_carry);
            end
            OP_SUB, OP_SBB: begin
                st_d.res   = ar_sum;
                st_d.flags = pack_flags(ar_sum, ar_half, 1'b1, ar_carry);
            end
            OP_CMP: begin
                st_d.flags = pack_flags(ar_sum, ar_half, 1'b1, ar_carry);
            end
            OP_AND, OP_XOR, OP_OR: begin
                st_d.res   = lg_res;
                st_d.flags = pack_flags(lg_res, lg_half, 1'b0, 1'b0);
            end
            OP_INC: begin
                st_d.res   = sp_res;
                st_d.flags = pack_flags(sp_res, sp_half, 1'b0, flags_in[FB_C]);
            end
            OP_DEC: begin
                st_d.res   = sp_res;
                st_d.flags = pack_flags(sp_res, sp_half, 1'b1, flags_in[FB_C]);
            end
            OP_WADD: begin
                st_d.wide        = wd_sum;
                st_d.flags[FB_C] = wd_carry;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q   = st_q.res;
    assign flags_q = st_q.flags;
    assign wide_q  = st_q.wide;

    // ---------------- assertions ----------------
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R4
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op) == OP_CMP) |-> (res_q == $past(acc)));

    // R10
    wide_flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op) == OP_WADD) |-> (flags_q[7:1] == $past(flags_in[7:1])));

    // R8
    step_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(op) == OP_INC || $past(op) == OP_DEC))
            |-> (flags_q[FB_C] == $past(flags_in[FB_C])));

    // R6
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(op) == OP_XOR || $past(op) == OP_OR))
            |-> (flags_q[FB_C] == 1'b0 && flags_q[FB_H] == 1'b0));

    // R5
    and_enh_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op) == OP_AND && $past(mode_enh)) |-> flags_q[FB_H]);

    // R3
    sub_marks_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(op) == OP_SUB || $past(op) == OP_SBB || $past(op) == OP_DEC))
            |-> flags_q[FB_V]);

    // R7
    parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op) <= OP_DEC && $past(op) != OP_CMP)
            |-> (flags_q[FB_P] == ~^res_q && flags_q[5] == 1'b0 && flags_q[3] == 1'b0));

    // R11
    unused_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op) > OP_WADD)
            |-> (res_q == $past(acc) && flags_q == $past(flags_in)));

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op;
    logic        mode_enh;
    logic [7:0]  acc, opnd, flags_in;
    logic [15:0] pair_a, pair_b;
    logic [7:0]  res_q, flags_q;
    logic [15:0] wide_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    acc_alu i_acc_alu (
        .clk(clk), .rst_n(rst_n), .op(op), .mode_enh(mode_enh),
        .acc(acc), .opnd(opnd), .flags_in(flags_in),
        .pair_a(pair_a), .pair_b(pair_b),
        .res_q(res_q), .flags_q(flags_q), .wide_q(wide_q)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        enh;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [7:0]  fi;
        logic [15:0] pa;
        logic [15:0] pb;
        logic [7:0]  er;
        logic [7:0]  ef;
        logic [15:0] ew;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b1, 8'h3A, 8'hC6, 8'h00, 16'h0100, 16'h0001, 8'h00, 8'h55, 16'h0100}, // R2 carry out
        '{4'd1,  1'b1, 8'h0F, 8'h00, 8'h01, 16'h0200, 16'h0001, 8'h10, 8'h10, 16'h0200}, // R2 carry in
        '{4'd2,  1'b1, 8'h10, 8'h01, 8'h00, 16'h0300, 16'h0001, 8'h0F, 8'h06, 16'h0300}, // R3
        '{4'd2,  1'b0, 8'h01, 8'h02, 8'h00, 16'h0400, 16'h0001, 8'hFF, 8'h87, 16'h0400}, // R3 borrow
        '{4'd3,  1'b1, 8'h05, 8'h05, 8'h01, 16'h0500, 16'h0001, 8'hFF, 8'h87, 16'h0500}, // R3 sbb
        '{4'd4,  1'b1, 8'h42, 8'h42, 8'hFF, 16'h0600, 16'h0001, 8'h42, 8'h56, 16'h0600}, // R4
        '{4'd5,  1'b1, 8'hF0, 8'h0F, 8'h00, 16'h0700, 16'h0001, 8'h00, 8'h54, 16'h0700}, // R5 enh
        '{4'd5,  1'b0, 8'h08, 8'h01, 8'h00, 16'h0800, 16'h0001, 8'h00, 8'h54, 16'h0800}, // R5 legacy h=1
        '{4'd5,  1'b0, 8'h03, 8'h07, 8'hFF, 16'h0900, 16'h0001, 8'h03, 8'h04, 16'h0900}, // R5 legacy h=0
        '{4'd6,  1'b0, 8'hFF, 8'h0F, 8'hFF, 16'h0A00, 16'h0001, 8'hF0, 8'h84, 16'h0A00}, // R6 xor
        '{4'd7,  1'b1, 8'h01, 8'h02, 8'h11, 16'h0B00, 16'h0001, 8'h03, 8'h04, 16'h0B00}, // R6 or
        '{4'd8,  1'b1, 8'h77, 8'hFF, 8'h01, 16'h0C00, 16'h0001, 8'h00, 8'h55, 16'h0C00}, // R8 wrap
        '{4'd8,  1'b1, 8'h77, 8'h3E, 8'hD6, 16'h0D00, 16'h0001, 8'h3F, 8'h04, 16'h0D00}, // R8
        '{4'd9,  1'b1, 8'h77, 8'h00, 8'h01, 16'h0E00, 16'h0001, 8'hFF, 8'h87, 16'h0E00}, // R9 wrap
        '{4'd9,  1'b1, 8'h77, 8'h11, 8'h00, 16'h0F00, 16'h0001, 8'h10, 8'h12, 16'h0F00}, // R9
        '{4'd10, 1'b1, 8'h5A, 8'h00, 8'hD6, 16'hFFFF, 16'h0001, 8'h5A, 8'hD7, 16'h0000}, // R10 carry
        '{4'd10, 1'b1, 8'h5A, 8'h00, 8'hFF, 16'h1234, 16'h1111, 8'h5A, 8'hFE, 16'h2345}, // R10
        '{4'd15, 1'b1, 8'hC3, 8'h99, 8'hA5, 16'h1000, 16'h0001, 8'hC3, 8'hA5, 16'h1000}, // R11
        '{4'd0,  1'b0, 8'h7F, 8'h01, 8'h00, 16'h1100, 16'h0001, 8'h80, 8'h90, 16'h1100}  // R7 sign
    };

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4:       return "R4";
            4'd5:       return "R5";
            4'd6, 4'd7: return "R6";
            4'd8:       return "R8";
            4'd9:       return "R9";
            4'd10:      return "R10";
            default:    return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op = v.op; mode_enh = v.enh; acc = v.a; opnd = v.b;
        flags_in = v.fi; pair_a = v.pa; pair_b = v.pb;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "res", {24'b0, res_q}, 32'h0);
        chk("R1", "flags", {24'b0, flags_q}, 32'h0);
        chk("R1", "wide", {16'b0, wide_q}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(posedge clk);
            #1;
            chk(tag_of(VECS[i].op), "res",   {24'b0, res_q},   {24'b0, VECS[i].er});
            chk(tag_of(VECS[i].op), "flags", {24'b0, flags_q}, {24'b0, VECS[i].ef});
            chk(tag_of(VECS[i].op), "wide",  {16'b0, wide_q},  {16'b0, VECS[i].ew});
        end

        // R12: new inputs must not reach outputs before the next rising edge
        @(negedge clk);
        drive(VECS[0]);
        #1;
        chk("R12", "res before edge", {24'b0, res_q}, {24'b0, VECS[NV-1].er});
        @(posedge clk);
        #1;
        chk("R12", "res after edge", {24'b0, res_q}, {24'b0, VECS[0].er});

        // R11 remaining unused codes
        for (int c = 11; c < 15; c++) begin
            @(negedge clk);
            op = 4'(c); acc = 8'(c * 7); flags_in = 8'(c * 13);
            @(posedge clk);
            #1;
            chk("R11", "res", {24'b0, res_q}, {24'b0, 8'(c * 7)});
            chk("R11", "flags", {24'b0, flags_q}, {24'b0, 8'(c * 13)});
        end

        // R1 reset applied mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "res mid", {24'b0, res_q}, 32'h0);
        chk("R1", "flags mid", {24'b0, flags_q}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule